// File: doc/BRIEF.md
# Programmable Card Cycle Timer

This block shapes the strobe timing of a removable-card bus access. A request on `start` runs three phases in fixed order. In the first phase the address-valid output is raised. In the second the command strobe is raised. In the last phase the block stays busy with both strobes low, so that the card can recover before the next access. One clock after the last phase ends, a single-cycle `done` pulse is given. The card can stretch the command phase by holding `card_wait` high.

Each phase length is set by an 8-bit timing byte. Bits 5-0 hold a multiplier M. Bits 7-6 select a scale factor P, which is 1, 16, 256 or 4096. The phase then lasts (M+1)×P clocks. Two independent timer sets each hold one byte per phase. An access uses the set that `set_sel` names in the cycle `start` is accepted. A configuration port writes the bytes, and a write acts on the running access as soon as it lands.

Top module: `card_cycle_timer`

## Requirements
- R1: While reset is held, and in the first cycle after it, `addr_valid`, `cmd_strobe`, `busy` and `done` are all low. All six timing bytes reset to zero.
- R2: When `start` is high while the block is idle, the block enters the setup phase in the next cycle. `addr_valid` then stays high for exactly the setup length.
- R3: A phase lasts (M+1)×P clocks. M is byte bits 5-0. Byte bits 7-6 select P: value 0 gives 1, value 1 gives 16, value 2 gives 256 and value 3 gives 4096.
- R4: `cmd_strobe` goes high in the cycle right after the last setup cycle. With `card_wait` low, it stays high for exactly the command length.
- R5: After the command phase, `busy` stays high with both strobes low for exactly the recovery length.
- R6: `done` is high for exactly one cycle, the cycle right after the last recovery cycle, and `busy` is low in that cycle. A `start` in that cycle is accepted.
- R7: Phases always run in the order setup, command, recovery, and none is skipped or repeated within one access.
- R8: The command phase ends in its first cycle that both has reached the programmed length and sees `card_wait` low. For a wait held over the first N command cycles, the command lasts max(length, N+1) cycles.
- R9: A `start` while `busy` is high has no effect on the running access.
- R10: `set_sel` is sampled only when a start is accepted. `cfg_set` selects the set written (0 or 1), and the two sets do not affect each other.
- R11: A write to a timing byte takes effect from the next cycle, including in the running phase. If the elapsed count already meets the new length, the phase ends in the cycle after the write.
- R12: `cfg_phase` selects the byte written: 0 is setup, 1 is command, 2 is recovery. A write with `cfg_phase` = 3 changes no timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Write strobe for a timing byte |
| cfg_set | input | 1 | Timer set written |
| cfg_phase | input | 2 | Byte written: 0 setup, 1 command, 2 recovery, 3 none |
| cfg_data | input | 8 | Timing byte: bits 7-6 scale select, bits 5-0 multiplier |
| start | input | 1 | Access request, honoured only when idle |
| set_sel | input | 1 | Timer set used by the access being started |
| card_wait | input | 1 | Card request to stretch the command phase |
| addr_valid | output | 1 | High during the setup phase |
| cmd_strobe | output | 1 | High during the command phase |
| busy | output | 1 | High from setup to the end of recovery |
| done | output | 1 | One-cycle pulse after recovery |

## Verification
Accesses are run with all-zero bytes, which gives single-cycle phases. They are also run with small multipliers at scale 1, and with every scale factor on set 1. The first case tells apart off-by-one errors in the phase end. The scaled cases catch a wrong shift for each select value and any mixing of the two sets. A wait held for less than and for longer than the programmed command length shows whether wait only gates the end of the phase or also adds to it. Writes landing mid-phase, both shorter and longer, separate live length lookup from a length snapshot taken at the phase start. Writes to the unused index, stray starts with the other set selected, and back-to-back starts on the `done` cycle are also tried.

// File: rtl/cct_pkg.sv
package cct_pkg;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_SETUP = 2'd1,
    PH_CMD   = 2'd2,
    PH_REC   = 2'd3
  } phase_t;

  // clocks spent in a phase: (multiplier + 1) scaled by 2^(select*step)
  function automatic int unsigned phase_len(input int unsigned mult,
                                            input int unsigned psel,
                                            input int unsigned step);
    return (mult + 1) << (psel * step);
  endfunction

  function automatic phase_t phase_after(input phase_t p);
    phase_t n;
    case (p)
      PH_SETUP: n = PH_CMD;
      PH_CMD:   n = PH_REC;
      default:  n = PH_IDLE;
    endcase
    return n;
  endfunction

endpackage

// File: rtl/cct_regbank.sv
module cct_regbank #(
  parameter int NUM_SETS = 2,
  parameter int REG_W    = 8,
  parameter int SET_W    = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [SET_W-1:0] wr_set,
  input  logic [1:0]       wr_idx,
  input  logic [REG_W-1:0] wr_data,
  input  logic [SET_W-1:0] rd_set,
  output logic [REG_W-1:0] rd_setup,
  output logic [REG_W-1:0] rd_cmd,
  output logic [REG_W-1:0] rd_rec
);

  localparam int PH_REGS = 3;
  localparam int FLAT_W  = NUM_SETS * PH_REGS * REG_W;

  logic [FLAT_W-1:0] flat;

  for (genvar s = 0; s < NUM_SETS; s++) begin : g_set
    for (genvar k = 0; k < PH_REGS; k++) begin : g_reg
      logic [REG_W-1:0] q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
          q <= '0;
        else if (wr_en && (wr_set == SET_W'(s)) && (wr_idx == 2'(k)))
          q <= wr_data;
      end
      assign flat[(s*PH_REGS + k)*REG_W +: REG_W] = q;
    end
  end

  logic [SET_W-1:0] rd_safe;
  assign rd_safe = (int'(rd_set) < NUM_SETS) ? rd_set : '0;

  assign rd_setup = flat[(int'(rd_safe)*PH_REGS + 0)*REG_W +: REG_W];
  assign rd_cmd   = flat[(int'(rd_safe)*PH_REGS + 1)*REG_W +: REG_W];
  assign rd_rec   = flat[(int'(rd_safe)*PH_REGS + 2)*REG_W +: REG_W];

  // R12
  idx_hole_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_idx == 2'd3) |=> (flat == $past(flat)))
    else $error("write to unused index altered a timing byte");

endmodule

// File: rtl/cct_phase_timer.sv
module cct_phase_timer #(
  parameter int CNT_W = 18
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic [CNT_W:0]   cur_len,
  output logic [CNT_W-1:0] elapsed,
  output logic             expired
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      elapsed <= '0;
    else if (restart)
      elapsed <= '0;
    else if (elapsed != CNT_MAX)
      elapsed <= elapsed + 1'b1;
  end

  // the current cycle is the last one once elapsed+1 reaches the length;
  // a length shortened below the count also ends the phase at once
  assign expired = ({1'b0, elapsed} + 1'b1) >= cur_len;

endmodule

// File: rtl/cct_seq.sv
module cct_seq
  import cct_pkg::*;
#(
  parameter int SET_W = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [SET_W-1:0] set_sel,
  input  logic             card_wait,
  input  logic             expired,
  output phase_t           phase,
  output logic [SET_W-1:0] act_set,
  output logic             done,
  output logic             phase_end,
  output logic             restart
);

  logic wait_hold;

  assign wait_hold = (phase == PH_CMD) && card_wait;
  assign phase_end = (phase != PH_IDLE) && expired && !wait_hold;
  assign restart   = (phase == PH_IDLE) || phase_end;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase   <= PH_IDLE;
      act_set <= '0;
      done    <= 1'b0;
    end else begin
      done <= (phase == PH_REC) && phase_end;
      if (phase == PH_IDLE) begin
        if (start) begin
          phase   <= PH_SETUP;
          act_set <= set_sel;
        end
      end else if (phase_end) begin
        phase <= phase_after(phase);
      end
    end
  end

  // R2
  start_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_IDLE && start) |=> (phase == PH_SETUP))
    else $error("idle start not accepted");

  // R9
  start_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase != PH_IDLE && start && !phase_end) |=> $stable(phase) && $stable(act_set))
    else $error("start while busy disturbed the access");

  // R7
  order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_CMD && $past(phase) != PH_CMD) |-> ($past(phase) == PH_SETUP))
    else $error("command phase not entered from setup");

  // R8
  wait_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_CMD && card_wait) |=> (phase == PH_CMD))
    else $error("command phase ended under wait");

  // R6
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done)
    else $error("done longer than one cycle");

  // R6
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (phase == PH_IDLE))
    else $error("done while busy");

endmodule

// File: rtl/card_cycle_timer.sv
module card_cycle_timer
  import cct_pkg::*;
#(
  parameter  int NUM_SETS = 2,
  parameter  int MULT_W   = 6,
  parameter  int PSEL_W   = 2,
  parameter  int PRE_STEP = 4,
  localparam int SET_W    = (NUM_SETS > 1) ? $clog2(NUM_SETS) : 1,
  localparam int REG_W    = MULT_W + PSEL_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [SET_W-1:0] cfg_set,
  input  logic [1:0]       cfg_phase,
  input  logic [REG_W-1:0] cfg_data,
  input  logic             start,
  input  logic [SET_W-1:0] set_sel,
  input  logic             card_wait,
  output logic             addr_valid,
  output logic             cmd_strobe,
  output logic             busy,
  output logic             done
);

  localparam int CNT_W = MULT_W + PRE_STEP * ((1 << PSEL_W) - 1);
  localparam int LEN_W = CNT_W + 1;

  phase_t           phase;
  logic [SET_W-1:0] act_set;
  logic [REG_W-1:0] rd_setup, rd_cmd, rd_rec, cur_reg;
  logic [LEN_W-1:0] cur_len;
  logic [CNT_W-1:0] elapsed;
  logic             expired, phase_end, restart;

  cct_regbank #(.NUM_SETS(NUM_SETS), .REG_W(REG_W), .SET_W(SET_W)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (cfg_we),
    .wr_set   (cfg_set),
    .wr_idx   (cfg_phase),
    .wr_data  (cfg_data),
    .rd_set   (act_set),
    .rd_setup (rd_setup),
    .rd_cmd   (rd_cmd),
    .rd_rec   (rd_rec)
  );

  always_comb begin
    case (phase)
      PH_SETUP: cur_reg = rd_setup;
      PH_CMD:   cur_reg = rd_cmd;
      default:  cur_reg = rd_rec;
    endcase
  end

  assign cur_len = LEN_W'(phase_len(int'(cur_reg[MULT_W-1:0]),
                                    int'(cur_reg[REG_W-1:MULT_W]),
                                    PRE_STEP));

  cct_phase_timer #(.CNT_W(CNT_W)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (restart),
    .cur_len (cur_len),
    .elapsed (elapsed),
    .expired (expired)
  );

  cct_seq #(.SET_W(SET_W)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .set_sel   (set_sel),
    .card_wait (card_wait),
    .expired   (expired),
    .phase     (phase),
    .act_set   (act_set),
    .done      (done),
    .phase_end (phase_end),
    .restart   (restart)
  );

  assign addr_valid = (phase == PH_SETUP);
  assign cmd_strobe = (phase == PH_CMD);
  assign busy       = (phase != PH_IDLE);

  // R2
  cnt_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && phase != $past(phase)) |-> (elapsed == '0))
    else $error("phase counter not restarted on phase entry");

  // R3
  len_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (cur_len >= LEN_W'(1)))
    else $error("phase length below one clock");

  // R5
  rec_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_REC) |-> (!addr_valid && !cmd_strobe && busy))
    else $error("strobe active during recovery");

endmodule

// File: tb/sim_card_cycle_timer.sv
`timescale 1ns/1ps
module sim_card_cycle_timer;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       cfg_we;
  logic [0:0] cfg_set;
  logic [1:0] cfg_phase;
  logic [7:0] cfg_data;
  logic       start;
  logic [0:0] set_sel;
  logic       card_wait;
  logic       addr_valid, cmd_strobe, busy, done;

  int n_chk  = 0;
  int n_fail = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  card_cycle_timer u0 (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_set(cfg_set),
    .cfg_phase(cfg_phase), .cfg_data(cfg_data), .start(start),
    .set_sel(set_sel), .card_wait(card_wait), .addr_valid(addr_valid),
    .cmd_strobe(cmd_strobe), .busy(busy), .done(done)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference ----------------
  int mreg [2][3];
  int m_ph, m_el, m_set;
  bit m_done;

  function automatic int ref_len(input int b);
    int scale = 1;
    for (int i = 0; i < b / 64; i++) scale = scale * 16;
    return (b % 64 + 1) * scale;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ph = 0; m_el = 0; m_set = 0; m_done = 0;
      for (int s = 0; s < 2; s++)
        for (int k = 0; k < 3; k++) mreg[s][k] = 0;
    end else begin
      m_done = 0;
      if (m_ph == 0) begin
        if (start) begin m_ph = 1; m_set = set_sel; m_el = 0; end
      end else if ((m_el + 1 >= ref_len(mreg[m_set][m_ph-1])) &&
                   !(m_ph == 2 && card_wait)) begin
        if (m_ph == 3) begin m_ph = 0; m_done = 1; end
        else m_ph = m_ph + 1;
        m_el = 0;
      end else begin
        m_el = m_el + 1;
      end
      if (cfg_we && cfg_phase != 2'd3) mreg[cfg_set][cfg_phase] = cfg_data;
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      chk(addr_valid == (m_ph == 1), "R2 addr_valid", addr_valid, m_ph == 1);
      chk(cmd_strobe == (m_ph == 2), "R4 cmd_strobe", cmd_strobe, m_ph == 2);
      chk(busy == (m_ph != 0), "R5 busy", busy, m_ph != 0);
      chk(done == m_done, "R6 done", done, m_done);
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic wr(input int s, input int idx, input int val);
    cfg_we = 1; cfg_set = 1'(s); cfg_phase = 2'(idx); cfg_data = 8'(val);
    @(negedge clk);
    cfg_we = 0;
  endtask

  // called at a negedge; returns at the negedge where done is seen
  task automatic access(input int s, input int n_wait, input int wr_c,
                        input int wr_val, input bit poke,
                        input int es, input int ec, input int er, input string tag);
    int sc = 0, cc = 0, rc = 0;
    bit bad_order = 0;
    start = 1; set_sel = 1'(s);
    @(negedge clk);
    start = 0;
    while (!done) begin
      if (addr_valid) begin sc++; if (cc > 0 || rc > 0) bad_order = 1; end
      if (cmd_strobe) begin cc++; if (rc > 0) bad_order = 1; end
      if (busy && !addr_valid && !cmd_strobe) rc++;
      card_wait = cmd_strobe && (cc - 1 < n_wait);
      if (cmd_strobe && cc - 1 == wr_c) begin
        cfg_we = 1; cfg_set = 1'(s); cfg_phase = 2'd1; cfg_data = 8'(wr_val);
      end else cfg_we = 0;
      if (poke && cmd_strobe && cc - 1 == 1) begin
        start = 1; set_sel = ~1'(s);
      end else start = 0;
      @(negedge clk);
    end
    card_wait = 0; cfg_we = 0; start = 0;
    chk(sc == es, {tag, " setup length"}, sc, es);
    chk(cc == ec, {tag, " command length"}, cc, ec);
    chk(rc == er, {tag, " recovery length (R5)"}, rc, er);
    chk(!bad_order, "R7 phase order", bad_order, 0);
  endtask

  initial begin
    rst_n = 0; cfg_we = 0; cfg_set = 0; cfg_phase = 0; cfg_data = 0;
    start = 0; set_sel = 0; card_wait = 0;
    repeat (3) @(negedge clk);
    chk(!addr_valid && !cmd_strobe && !busy && !done, "R1 reset outputs",
        {addr_valid, cmd_strobe, busy, done}, 0);
    rst_n = 1;
    @(negedge clk);
    chk(!busy && !done, "R1 idle after reset", {busy, done}, 0);

    access(0, 0, -1, 0, 0, 1, 1, 1, "R2 zero bytes");
    wr(0, 0, 8'h03); wr(0, 1, 8'h05); wr(0, 2, 8'h02);
    access(0, 0, -1, 0, 0, 4, 6, 3, "R4 set0");
    wr(1, 0, 8'h41); wr(1, 1, 8'h80); wr(1, 2, 8'hC0);
    access(1, 0, -1, 0, 0, 32, 256, 4096, "R3 scales");
    access(0, 0, -1, 0, 0, 4, 6, 3, "R10 set0 untouched");
    access(0, 10, -1, 0, 0, 4, 11, 3, "R8 long wait");
    access(0, 3, -1, 0, 0, 4, 6, 3, "R8 short wait");
    access(0, 0, -1, 0, 1, 4, 6, 3, "R9 start while busy");
    access(0, 0, 2, 8'h14, 0, 4, 21, 3, "R11 lengthen");
    access(0, 0, 5, 8'h01, 0, 4, 7, 3, "R11 shorten");
    wr(0, 3, 8'hFF);
    access(0, 0, -1, 0, 0, 4, 2, 3, "R12 unused index");
    access(0, 0, -1, 0, 0, 4, 2, 3, "R6 back to back");
    @(negedge clk);
    chk(!busy && !done, "R6 idle after done", {busy, done}, 0);

    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

endmodule